// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Control Path

This block models the synchronous front end of a pipelined burst static RAM together with a small internal storage array. At every rising clock edge it samples three chip-select pins, two address-strobe pins, an advance pin and a write strobe. From these it picks one of four actions:

- release the device;
- open a burst at the address on the bus;
- step to the next address in the burst;
- stay on the current address.

It then reads or writes the chosen location.

The two address strobes do not follow the same rules. The processor-side strobe wins over the controller-side strobe and always starts a read. The controller-side strobe takes its read or write direction from the write strobe. While the primary select is inactive, the controller-side strobe releases the device and the processor-side strobe is ignored. When neither strobe is low, the advance pin decides between continuing and suspending the current burst. This holds whatever the state of the primary select.

Read data is pipelined: it leaves a register one clock after the edge that accepted the address. Write data is taken on the same edge as its address. The bidirectional data bus is split into an input port, an output port and an output-drive indication. An asynchronous output-enable pin gates that indication without waiting for a clock.

Top module: `sbsram_ctl`

## Requirements
- R1: The device is selected only when `ce2` is 1 and `ce3_n` is 0. With `ce1_n` at 0, an unselected device and either strobe low, the cycle is a release: nothing is written, `drive_o` is 0 in the following cycle, and the open burst ends.
- R2: With `ce1_n` at 1 and `ads_ctl_n` at 0, the cycle is a release, whatever `ads_proc_n`, `adv_n` and `we_n` are.
- R3: With `ce1_n` at 0, the device selected and `ads_proc_n` at 0, a read burst opens at `addr_i`. `we_n` and `ads_ctl_n` are ignored, so nothing is written.
- R4: With `ce1_n` at 0, the device selected, `ads_proc_n` at 1 and `ads_ctl_n` at 0, a burst opens at `addr_i`. It is a write when `we_n` is 0 and a read when `we_n` is 1.
- R5: With both strobes at 1 and `adv_n` at 0, the burst steps forward. The two least significant address bits count up by one and wrap modulo 4, and the upper bits stay fixed. The access is a write when `we_n` is 0. This works with `ce1_n` at 1, and in that case `ads_proc_n` is ignored.
- R6: With both strobes at 1 and `adv_n` at 1, the burst is suspended. The current address is accessed again, as a read or a write according to `we_n`.
- R7: A read drives `dout_o` with the addressed word, and raises `drive_o`, in the clock cycle that follows the accepting edge, provided `oe_n` is 0.
- R8: `oe_n` at 1 forces `drive_o` to 0 immediately, without a clock edge. `oe_n` at 0 raises `drive_o` only in a cycle that carries read data.
- R9: A write stores `din_i` on its accepting edge. A later read of that address returns the stored word.
- R10: After reset, or after any release, step and suspend cycles neither read nor write until a new burst is opened.
- R11: While `rst_n` is low, `drive_o` is 0.
- R12: Holding `ads_proc_n` at 1 and `ads_ctl_n` at 0 gives single-cycle accesses, with a new external address taken on every clock.

Encodings: all `_n` pins are active low, `ce2` is active high, and a write strobe of 0 means write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce1_n | input | 1 | Primary select, active low |
| ce2 | input | 1 | Secondary select, active high |
| ce3_n | input | 1 | Secondary select, active low |
| ads_proc_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low (high suspends) |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_i | input | ADDR_W | External address |
| din_i | input | DATA_W | Write data half of the data bus |
| dout_o | output | DATA_W | Read data half of the data bus |
| drive_o | output | 1 | High when the data bus would be driven by the device |

## Verification
The bound checker watches, on every clock, how the address register responds to each decoded action:

- it must load on a burst start;
- it must step and wrap only the low field on a step;
- it must stay put on a suspend.

The checker also confirms that a release silences the driver and closes the burst, that a write start never drives, and that an enabled read always drives one cycle later. Data itself is left to the bench's reference model:

- words landing in the right locations;
- read-back after wrapping bursts;
- ignored write strobes on processor-started bursts;
- the asynchronous effect of the output enable between edges;
- the suppression of steps issued after a release.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Action chosen for one clock edge
  typedef enum logic [1:0] {
    ACT_DESEL = 2'd0,
    ACT_START = 2'd1,
    ACT_NEXT  = 2'd2,
    ACT_HOLD  = 2'd3
  } sbs_act_e;

  typedef struct packed {
    sbs_act_e act;
    logic     wr;
  } sbs_cmd_t;

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic     ce1_n,
  input  logic     ce2,
  input  logic     ce3_n,
  input  logic     ads_proc_n,
  input  logic     ads_ctl_n,
  input  logic     adv_n,
  input  logic     we_n,
  output sbs_cmd_t cmd
);

  logic sel;
  logic any_strobe;
  sbs_act_e seq_act;

  assign sel        = ce2 & ~ce3_n;
  assign any_strobe = ~ads_proc_n | ~ads_ctl_n;
  assign seq_act    = adv_n ? ACT_HOLD : ACT_NEXT;

  always_comb begin
    cmd.act = ACT_DESEL;
    cmd.wr  = 1'b0;
    if (ce1_n) begin
      // primary select off: only the controller strobe matters
      if (ads_ctl_n) begin
        cmd.act = seq_act;
        cmd.wr  = ~we_n;
      end
    end else if (any_strobe) begin
      if (sel) begin
        cmd.act = ACT_START;
        // processor strobe has priority and always reads
        cmd.wr  = ads_proc_n & ~we_n;
      end
    end else begin
      cmd.act = seq_act;
      cmd.wr  = ~we_n;
    end
  end

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr
  import sbs_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sbs_cmd_t      cmd,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] op_addr,
  output logic          op_valid,
  output logic [AW-1:0] addr_q,
  output logic          active_q
);

  localparam logic [BW-1:0] STEP = {{(BW-1){1'b0}}, 1'b1};

  logic [BW-1:0] low_next;
  logic [AW-1:0] addr_d;
  logic          addr_en;
  logic          active_d;

  assign low_next = addr_q[BW-1:0] + STEP;

  // operand selection for the current edge
  always_comb begin
    op_addr  = addr_q;
    op_valid = 1'b0;
    unique case (cmd.act)
      ACT_START: begin
        op_addr  = ext_addr;
        op_valid = 1'b1;
      end
      ACT_NEXT: begin
        op_addr  = {addr_q[AW-1:BW], low_next};
        op_valid = active_q;
      end
      ACT_HOLD: begin
        op_valid = active_q;
      end
      default: begin
        op_valid = 1'b0;
      end
    endcase
  end

  // next state
  always_comb begin
    addr_en  = op_valid;
    addr_d   = op_addr;
    active_d = (cmd.act == ACT_START) | (active_q & (cmd.act != ACT_DESEL));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_d;
      if (addr_en) begin
        addr_q <= addr_d;
      end
    end
  end

endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_wr,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_en;
  logic          rvalid_d;
  logic [DW-1:0] rdata_d;

  assign wr_en    = op_valid & op_wr;
  assign rvalid_d = op_valid & ~op_wr;
  assign rdata_d  = rvalid_d ? mem[op_addr] : rdata_q;

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[op_addr] <= wdata;
    end
  end

  // pipelined read register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctl_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  sbs_cmd_t          cmd;
  logic [ADDR_W-1:0] op_addr;
  logic              op_valid;
  logic [ADDR_W-1:0] burst_addr_q;
  logic              burst_active_q;
  logic              rvalid_q;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  sbs_decode i_decode (
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .ads_proc_n (ads_proc_n),
    .ads_ctl_n  (ads_ctl_n),
    .adv_n      (adv_n),
    .we_n       (we_n),
    .cmd        (cmd)
  );

  sbs_burst_addr #(
    .AW (ADDR_W),
    .BW (BURST_W)
  ) i_burst_addr (
    .clk      (clk),
    .rst_n    (rst_ns),
    .cmd      (cmd),
    .ext_addr (addr_i),
    .op_addr  (op_addr),
    .op_valid (op_valid),
    .addr_q   (burst_addr_q),
    .active_q (burst_active_q)
  );

  sbs_store #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_ns),
    .op_valid (op_valid),
    .op_wr    (cmd.wr),
    .op_addr  (op_addr),
    .wdata    (din_i),
    .rdata_q  (dout_o),
    .rvalid_q (rvalid_q)
  );

  // asynchronous output-enable gating of the driver indication
  assign drive_o = rvalid_q & ~oe_n;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
  parameter int AW = 8,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          ads_proc_n,
  input logic          ads_ctl_n,
  input logic          adv_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr_i,
  input logic [AW-1:0] addr_q,
  input logic          active_q,
  input logic          drive_o
);

  localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

  logic sel, desel_in, start_in, rd_start, wr_start, seq_in, next_in, hold_in;
  logic [BW-1:0] low_q;

  assign sel      = ce2 & ~ce3_n;
  assign desel_in = (ce1_n & ~ads_ctl_n) | (~ce1_n & ~sel & (~ads_proc_n | ~ads_ctl_n));
  assign start_in = ~ce1_n & sel & (~ads_proc_n | ~ads_ctl_n);
  assign rd_start = start_in & (~ads_proc_n | we_n);
  assign wr_start = start_in & ads_proc_n & ~we_n;
  assign seq_in   = ads_ctl_n & (ce1_n | ads_proc_n);
  assign next_in  = seq_in & ~adv_n;
  assign hold_in  = seq_in & adv_n;
  assign low_q    = addr_q[BW-1:0];

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    desel_in |=> !drive_o); // R1
  AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_ns)
    desel_in |=> !active_q); // R10
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_ns)
    start_in |=> (addr_q == $past(addr_i))); // R3
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_start |=> !drive_o); // R4
  AST_NEXT_WRAPS: assert property (@(posedge clk) disable iff (!rst_ns)
    (next_in && active_q) |=> (low_q == ($past(low_q) + ONE))); // R5
  AST_NEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_ns)
    next_in |=> (addr_q[AW-1:BW] == $past(addr_q[AW-1:BW]))); // R5
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_ns)
    hold_in |=> $stable(addr_q)); // R6
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_start |=> (drive_o || oe_n)); // R7
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_ns)
    oe_n |-> !drive_o); // R8

endmodule

bind sbsram_ctl sbs_chk #(
  .AW (ADDR_W),
  .BW (BURST_W)
) i_sbs_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .ce1_n      (ce1_n),
  .ce2        (ce2),
  .ce3_n      (ce3_n),
  .ads_proc_n (ads_proc_n),
  .ads_ctl_n  (ads_ctl_n),
  .adv_n      (adv_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .addr_i     (addr_i),
  .addr_q     (burst_addr_q),
  .active_q   (burst_active_q),
  .drive_o    (drive_o)
);

// File: tb/test_sbsram_ctl.sv
module test_sbsram_ctl;

  localparam int CLK_P = 10;
  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          rst_n;
  logic          ce1_n, ce2, ce3_n, ads_proc_n, ads_ctl_n, adv_n, we_n, oe_n;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] din_i;
  logic [DW-1:0] dout_o;
  logic          drive_o;

  sbsram_ctl #(.ADDR_W(AW), .DATA_W(DW), .BURST_W(2)) i_sbsram_ctl (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ads_proc_n(ads_proc_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .we_n(we_n),
    .oe_n(oe_n), .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o), .drive_o(drive_o)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference
  logic [DW-1:0] m_mem [DEPTH];
  int            m_addr   = 0;
  bit            m_active = 0;
  bit            m_pend   = 0;
  logic [DW-1:0] m_data   = '0;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit en, wr, ok;
    int kind, a;
    en = ce2 && !ce3_n;
    wr = 0;
    kind = 0;
    if (ce1_n) begin
      if (ads_ctl_n) begin kind = adv_n ? 3 : 2; wr = !we_n; end
    end else if (!ads_proc_n || !ads_ctl_n) begin
      if (en) begin kind = 1; wr = ads_proc_n && !we_n; end
    end else begin
      kind = adv_n ? 3 : 2;
      wr = !we_n;
    end
    ok = 0;
    a  = m_addr;
    case (kind)
      1: begin a = int'(addr_i); ok = 1; m_active = 1; end
      2: begin a = (m_addr & ~3) | ((m_addr + 1) & 3); ok = m_active; end
      3: ok = m_active;
      default: m_active = 0;
    endcase
    m_pend = ok && !wr;
    if (ok) begin
      m_addr = a;
      if (wr) m_mem[a] = din_i;
      else    m_data = m_mem[a];
    end
  endtask

  task automatic cycle(input string tag);
    bit exp_drv;
    @(posedge clk);
    model_step();
    @(negedge clk);
    exp_drv = m_pend && !oe_n;
    chk(tag, "drive", {31'b0, drive_o}, {31'b0, exp_drv});
    if (exp_drv) chk(tag, "dout", dout_o, m_data);
  endtask

  task automatic drv(input logic c1, input logic c2, input logic c3, input logic ap,
                     input logic ac, input logic av, input logic w,
                     input int a, input logic [DW-1:0] d);
    ce1_n = c1; ce2 = c2; ce3_n = c3; ads_proc_n = ap; ads_ctl_n = ac;
    adv_n = av; we_n = w; addr_i = AW'(a); din_i = d;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return 32'h5A00_0000 ^ (DW'(i) * 32'h0101_0111);
  endfunction

  initial begin : watchdog
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    oe_n  = 1'b0;
    drv(1, 1, 0, 1, 0, 1, 1, 0, '0);
    repeat (3) begin
      @(negedge clk);
      chk("R11", "drive in reset", {31'b0, drive_o}, '0);
    end
    rst_n = 1'b1;
    repeat (3) cycle("R11");

    // R10: step and suspend right after reset touch nothing
    drv(0, 1, 0, 1, 1, 0, 1, 0, '0); cycle("R10");
    drv(1, 1, 0, 0, 1, 1, 1, 0, '0); cycle("R10");

    // R12 / R4 / R9: fill every location with single-cycle writes
    for (int i = 0; i < DEPTH; i++) begin
      drv(0, 1, 0, 1, 0, 1, 0, i, pat(i));
      cycle("R12");
    end
    // R12 / R7: single-cycle reads
    for (int i = 0; i < 16; i++) begin
      drv(0, 1, 0, 1, 0, 1, 1, (i * 37) % DEPTH, '0);
      cycle("R7");
    end

    // R3: processor strobe reads despite write strobe and controller strobe
    drv(0, 1, 0, 0, 0, 1, 0, 8'h45, 32'hDEAD_BEEF); cycle("R3");
    // R5: steps with ce1_n high and processor strobe ignored, wrapping 46,47,44
    drv(1, 1, 0, 0, 1, 0, 1, 0, '0); cycle("R5");
    drv(1, 1, 0, 1, 1, 0, 1, 0, '0); cycle("R5");
    drv(0, 1, 0, 1, 1, 0, 1, 0, '0); cycle("R5");
    // R6: suspend reads the same word, then writes it
    drv(0, 1, 0, 1, 1, 1, 1, 0, '0); cycle("R6");
    drv(1, 0, 1, 1, 1, 1, 0, 0, 32'h0606_0606); cycle("R6");
    drv(0, 1, 0, 1, 1, 1, 1, 0, '0); cycle("R6");

    // R4 / R5 / R9: controller-started write burst wrapping from 9E
    drv(0, 1, 0, 1, 0, 1, 0, 8'h9E, 32'h1111_0001); cycle("R4");
    drv(0, 1, 0, 1, 1, 0, 0, 0, 32'h1111_0002); cycle("R5");
    drv(1, 1, 0, 1, 1, 0, 0, 0, 32'h1111_0003); cycle("R5");
    drv(0, 1, 0, 1, 1, 0, 0, 0, 32'h1111_0004); cycle("R5");
    drv(0, 1, 0, 1, 0, 1, 1, 8'h9C, '0); cycle("R9");
    for (int i = 0; i < 4; i++) begin
      drv(0, 1, 0, 1, 1, 0, 1, 0, '0); cycle("R9");
    end

    // R8: output enable gates asynchronously
    drv(0, 1, 0, 1, 0, 1, 1, 8'h10, '0); cycle("R8");
    oe_n = 1'b1; #1;
    chk("R8", "drive after oe_n high", {31'b0, drive_o}, '0);
    oe_n = 1'b0; #1;
    chk("R8", "drive after oe_n low", {31'b0, drive_o}, 32'd1);
    drv(0, 1, 0, 1, 1, 0, 1, 0, '0); oe_n = 1'b1; cycle("R8");
    drv(0, 1, 0, 1, 0, 1, 0, 8'h11, 32'h7777_0000); oe_n = 1'b0; cycle("R8");

    // R2: release with ce1_n high, write strobe low, processor strobe low
    drv(1, 1, 0, 0, 0, 0, 0, 8'h20, 32'hBAD0_0002); cycle("R2");
    // R10: steps after release write nothing
    drv(0, 1, 0, 1, 1, 0, 0, 0, 32'hBAD0_0010); cycle("R10");
    drv(0, 1, 0, 1, 1, 1, 0, 0, 32'hBAD0_0011); cycle("R10");
    // R1: unselected device with either strobe
    drv(0, 0, 0, 0, 1, 1, 0, 8'h21, 32'hBAD0_0001); cycle("R1");
    drv(0, 1, 1, 1, 0, 1, 0, 8'h22, 32'hBAD0_0003); cycle("R1");
    drv(0, 0, 1, 0, 0, 1, 1, 8'h23, '0); cycle("R1");
    drv(0, 1, 0, 1, 0, 1, 1, 8'h20, '0); cycle("R2");
    drv(0, 1, 0, 1, 0, 1, 1, 8'h21, '0); cycle("R1");
    drv(0, 1, 0, 1, 0, 1, 1, 8'h22, '0); cycle("R1");

    // mixed traffic against the reference
    for (int i = 0; i < 2000; i++) begin
      int unsigned r;
      r = $urandom;
      drv(r[0] & r[1], ~(r[2] & r[3] & r[4]), r[5] & r[6] & r[7], r[8] | r[9],
          r[10] & r[11], r[12], r[13], int'(r[31:24]), {r[23:16], r[31:8]});
      oe_n = r[14] & r[15] & r[16];
      cycle("MIX");
    end
    oe_n = 1'b0;

    // R9: final sweep of the whole array
    for (int i = 0; i < DEPTH; i++) begin
      drv(0, 1, 0, 1, 0, 1, 1, i, '0);
      cycle("R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule